// File: doc/BRIEF.md
# Board-Variant Display Control and Card Status Registers

This block holds two words of a board's system-control space: a display-control word and a read-only card-slot status word. A static board-type parameter selects the display word's reset value and write mask, whether a 2-bit display format select is driven out, and where the write-protect flag lands in the status word. The block has no display logic of its own. Other logic reads the display word and the optional format select.

Software writes through a simple single-cycle write strobe with a byte offset and data. Reads are combinational from the same offset bus. The card-present and write-protect inputs are level signals from a slot connector. Each passes through a two-flop synchronizer, and the synchronized value is the status bit.

Top module: `board_disp_card_regs`

## Requirements
- R1: After reset the display word is 0x0000_1F00 on boards 0x100, 0x140, 0x178 and 0x182, and 0 on board 0x190 or any other board. The format select is 0.
- R2: On boards 0x100 and 0x140, a display write keeps bits 13:8 and replaces every other bit with the write data.
- R3: On boards 0x178 and 0x182, a display write changes only bit 7. All other bits keep their value.
- R4: On board 0x190 and on unknown boards, the display word reads 0 and writes have no effect.
- R5: On board 0x100, each display write loads write-data bits 1:0 into the 2-bit format select output. On every other board that output is constantly 0.
- R6: Bit 0 of the status word shows the card-present input. A change shows up after the second rising clock edge, not after the first.
- R7: The write-protect input shows up in status bit 2 on boards 0x100 and 0x140, and in bit 1 on all other boards. It has the same two-edge latency. All other status bits read 0.
- R8: The display word sits at byte offset 0x50 and the status word at 0x48. Other offsets read 0. A write to any other offset, including 0x48, changes neither word.
- R9: The format select holds its value across cycles with no display write, including writes to other offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | AW | Byte offset for the write and the read |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i, combinational |
| card_present_i | input | 1 | Card-present level, asynchronous |
| card_wprot_i | input | 1 | Write-protect level, asynchronous |
| fmt_sel_o | output | 2 | Display format select (board 0x100 only) |

## Verification
The board type is fixed when the block is built, so no single instance shows the full behaviour. The bench builds five copies, one for each board class, drives them from the same bus and inputs, and compares each against its own model. The hardest case is the synchronizer latency on a status bit whose position depends on the board. The bench changes a card input, reads the status word after one edge (old value expected) and again after two edges (new value expected). Random writes at the display offset and at other offsets then exercise the read-only bits and the holding of the format select.

// File: rtl/disp_card_pkg.sv
package disp_card_pkg;

  localparam logic [11:0] BRD_MUXED  = 12'h100;
  localparam logic [11:0] BRD_PLAIN  = 12'h140;
  localparam logic [11:0] BRD_BIT7_A = 12'h178;
  localparam logic [11:0] BRD_BIT7_B = 12'h182;
  localparam logic [11:0] BRD_BLANK  = 12'h190;

  localparam logic [31:0] MON_ID_VGA   = 32'h0000_1F00;
  localparam logic [31:0] MON_ID_FIELD = 32'h0000_3F00;
  localparam logic [31:0] BIT7_ONLY    = 32'h0000_0080;

  function automatic logic [31:0] disp_wmask(logic [11:0] brd);
    case (brd)
      BRD_MUXED, BRD_PLAIN:   return ~MON_ID_FIELD;
      BRD_BIT7_A, BRD_BIT7_B: return BIT7_ONLY;
      default:                return '0;
    endcase
  endfunction

  function automatic logic [31:0] disp_rst(logic [11:0] brd);
    case (brd)
      BRD_MUXED, BRD_PLAIN, BRD_BIT7_A, BRD_BIT7_B: return MON_ID_VGA;
      default:                                      return '0;
    endcase
  endfunction

  function automatic int unsigned wprot_pos(logic [11:0] brd);
    return (brd == BRD_MUXED || brd == BRD_PLAIN) ? 2 : 1;
  endfunction

  function automatic bit has_fmt_mux(logic [11:0] brd);
    return brd == BRD_MUXED;
  endfunction

endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/disp_reg.sv
module disp_reg
  import disp_card_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned MUX_W    = 2,
  parameter logic [11:0] BOARD_ID = BRD_MUXED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    q_o,
  output logic [MUX_W-1:0] mux_o
);
  localparam logic [DW-1:0] WMASK = DW'(disp_wmask(BOARD_ID));
  localparam logic [DW-1:0] RSTV  = DW'(disp_rst(BOARD_ID));

  logic [DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RSTV;
    else if (wr_i) q <= (q & ~WMASK) | (wdata_i & WMASK);
  end
  assign q_o = q;

  generate
    if (has_fmt_mux(BOARD_ID)) begin : g_mux
      logic [MUX_W-1:0] mux_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   mux_q <= '0;
        else if (wr_i) mux_q <= wdata_i[MUX_W-1:0];
      end
      assign mux_o = mux_q;
    end else begin : g_nomux
      assign mux_o = '0;
    end
  endgenerate
endmodule

// File: rtl/card_stat.sv
module card_stat
  import disp_card_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter logic [11:0] BOARD_ID = BRD_MUXED
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          present_i,
  input  logic          wprot_i,
  output logic [DW-1:0] word_o
);
  localparam int unsigned WP_POS = wprot_pos(BOARD_ID);

  logic [1:0] sync;

  sync_2ff #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({wprot_i, present_i}),
    .q_o    (sync)
  );

  always_comb begin
    word_o         = '0;
    word_o[0]      = sync[0];
    word_o[WP_POS] = sync[1];
  end
endmodule

// File: rtl/board_disp_card_regs.sv
module board_disp_card_regs
  import disp_card_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 8,
  parameter logic [11:0] BOARD_ID  = BRD_MUXED,
  parameter logic [7:0]  DISP_OFFS = 8'h50,
  parameter logic [7:0]  CARD_OFFS = 8'h48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          card_present_i,
  input  logic          card_wprot_i,
  output logic [1:0]    fmt_sel_o
);
  localparam logic [AW-1:0] DISP_A = AW'(DISP_OFFS);
  localparam logic [AW-1:0] CARD_A = AW'(CARD_OFFS);

  logic          disp_hit, card_hit;
  logic [DW-1:0] disp_q, card_q;

  assign disp_hit = addr_i == DISP_A;
  assign card_hit = addr_i == CARD_A;

  disp_reg #(.DW(DW), .MUX_W(2), .BOARD_ID(BOARD_ID)) u_disp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i && disp_hit),
    .wdata_i (wdata_i),
    .q_o     (disp_q),
    .mux_o   (fmt_sel_o)
  );

  card_stat #(.DW(DW), .BOARD_ID(BOARD_ID)) u_card (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .present_i (card_present_i),
    .wprot_i   (card_wprot_i),
    .word_o    (card_q)
  );

  always_comb begin
    if (disp_hit)      rdata_o = disp_q;
    else if (card_hit) rdata_o = card_q;
    else               rdata_o = '0;
  end
endmodule

// File: rtl/disp_card_chk.sv
module disp_card_chk
  import disp_card_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 8,
  parameter logic [11:0] BOARD_ID  = BRD_MUXED,
  parameter logic [7:0]  DISP_OFFS = 8'h50
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] disp_q,
  input logic [DW-1:0] card_q,
  input logic          card_present_i,
  input logic          card_wprot_i,
  input logic [1:0]    fmt_sel_o
);
  localparam logic [DW-1:0] WMASK  = DW'(disp_wmask(BOARD_ID));
  localparam int unsigned   WP_POS = wprot_pos(BOARD_ID);
  localparam logic [DW-1:0] CMASK  = DW'(1) | (DW'(1) << WP_POS);

  logic       disp_wr;
  logic [1:0] cyc;

  assign disp_wr = wr_en_i && (addr_i == AW'(DISP_OFFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 2'd1;
  end

  p_ro_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((disp_q & ~WMASK) == ($past(disp_q) & ~WMASK)));

  p_no_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_wr |=> $stable(disp_q));

  p_mux_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_wr |=> $stable(fmt_sel_o));

  p_mux_none_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_fmt_mux(BOARD_ID) |-> fmt_sel_o == 2'b00);

  p_card_rsvd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_q & ~CMASK) == '0);

  p_card_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc >= 2 |-> card_q[0] == $past(card_present_i, 2));

  p_wp_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc >= 2 |-> card_q[WP_POS] == $past(card_wprot_i, 2));
endmodule

bind board_disp_card_regs disp_card_chk #(
  .DW(DW), .AW(AW), .BOARD_ID(BOARD_ID), .DISP_OFFS(DISP_OFFS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .addr_i         (addr_i),
  .disp_q         (disp_q),
  .card_q         (card_q),
  .card_present_i (card_present_i),
  .card_wprot_i   (card_wprot_i),
  .fmt_sel_o      (fmt_sel_o)
);

// File: tb/tb_board_disp_card_regs.sv
`timescale 1ns/1ps
module tb_board_disp_card_regs;
  localparam int NB = 5;
  localparam logic [11:0] BRD [NB] = '{12'h100, 12'h140, 12'h178, 12'h182, 12'h190};

  logic        clk = 0, rst_ni = 0, wr_en = 0, cp = 0, wp = 0;
  logic [7:0]  addr = 8'h50;
  logic [31:0] wdata = '0;
  logic [31:0] rdata [NB];
  logic [1:0]  fsel  [NB];
  logic [31:0] exp_disp [NB];
  logic [1:0]  exp_mux;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NB; g++) begin : g_dut
    board_disp_card_regs #(.BOARD_ID(BRD[g])) dut (
      .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata[g]), .card_present_i(cp),
      .card_wprot_i(wp), .fmt_sel_o(fsel[g]));
  end

  function automatic logic [31:0] m_mask(logic [11:0] b);
    if (b == 12'h100 || b == 12'h140) return 32'hFFFF_C0FF;
    if (b == 12'h178 || b == 12'h182) return 32'h0000_0080;
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_rst(logic [11:0] b);
    return (b == 12'h190) ? 32'h0 : 32'h1F00;
  endfunction

  function automatic logic [31:0] m_card(logic [11:0] b, logic p, logic w);
    logic [31:0] v = {31'd0, p};
    if (b == 12'h100 || b == 12'h140) v[2] = w; else v[1] = w;
    return v;
  endfunction

  function automatic string disp_tag(int g);
    if (g < 2) return "R2";
    if (g < 4) return "R3";
    return "R4";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    if (a == 8'h50) begin
      for (int g = 0; g < NB; g++)
        exp_disp[g] = (exp_disp[g] & ~m_mask(BRD[g])) | (d & m_mask(BRD[g]));
      exp_mux = d[1:0];
    end
  endtask

  task automatic check_disp(string tag);
    addr = 8'h50; #0.5;
    for (int g = 0; g < NB; g++) chk({tag, "/", disp_tag(g)}, rdata[g], exp_disp[g]);
    chk({tag, "/R5 mux"}, {30'd0, fsel[0]}, {30'd0, exp_mux});
    for (int g = 1; g < NB; g++) chk({tag, "/R5 nomux"}, {30'd0, fsel[g]}, 32'd0);
  endtask

  task automatic check_card(string tag, logic p, logic w);
    addr = 8'h48; #0.5;
    for (int g = 0; g < NB; g++) chk(tag, rdata[g], m_card(BRD[g], p, w));
  endtask

  task automatic set_card(logic p, logic w);
    logic op = cp, ow = wp;
    @(negedge clk); cp = p; wp = w;
    @(posedge clk); @(negedge clk);
    check_card("R6/R7 one edge, old value", op, ow);
    @(posedge clk); @(negedge clk);
    check_card("R6/R7 two edges, new value", p, w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd2024);
    for (int g = 0; g < NB; g++) exp_disp[g] = m_rst(BRD[g]);
    exp_mux = 2'b00;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check_disp("R1 reset");
    check_card("R1 reset card", 1'b0, 1'b0);

    wr(8'h50, 32'hFFFF_FFFF); check_disp("R2 all ones");
    wr(8'h50, 32'h0000_0000); check_disp("R3 all zeros");
    wr(8'h50, 32'h0000_3F82); check_disp("R4 ro pattern");
    wr(8'h48, 32'hFFFF_FFFD); check_disp("R8 write card offset");
    wr(8'h44, 32'h1234_5679); check_disp("R9 write other offset");
    addr = 8'h44; #0.5;
    for (int g = 0; g < NB; g++) chk("R8 other offset reads 0", rdata[g], 32'd0);

    set_card(1'b1, 1'b0);
    set_card(1'b0, 1'b1);
    set_card(1'b1, 1'b1);
    wr(8'h48, 32'h0); check_card("R8 card ignores write", 1'b1, 1'b1);
    set_card(1'b0, 1'b0);

    for (int i = 0; i < 300; i++) begin
      r = $urandom % 4;
      if (r < 2) wr(8'h50, $urandom);
      else if (r == 2) wr(8'($urandom) & 8'hFC, $urandom);
      else set_card(1'($urandom), 1'($urandom));
      check_disp("rand");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule